// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block keeps one direct-mapped cache coherent with its peers on a shared snooping bus. Coherence works by update, not invalidation. When a line is held by several caches, a store broadcasts the new word and every other copy is patched in place. Each line holds two words and has one of five states: invalid, exclusive, shared-clean, shared-owned or modified. The shared-owned state marks the single sharer that must later write the dirty line back to memory.

The processor side takes one load or store at a time. A request names a line address, a word select and, for a store, the data. The request is held until `cpu_done_o` pulses. On the bus side the block requests ownership from an external arbiter. Once granted, it issues a line read, a word update or a line write-back. It samples the wired-OR shared signal while it holds the grant. Fill data arrives later on a separate response port, from whichever agent supplies it.

Every bus cycle from another master is seen on the snoop port. On a snooped read that hits, the block asserts its shared contribution, and an owning copy also drives the whole line out. On a snooped update that hits, the new word is written into the local copy.

Top module: `dcoh_ctrl`

## Requirements
- R1: After reset no line is valid. A snooped read gets neither shared nor flush, and `bus_req_o` and `cpu_done_o` are low.
- R2: A fill loads both words of the line together. The word not named by the missing request then hits with the filled value and makes no bus request.
- R3: A load miss requests the bus with command BusRd (code 1) and the line address, then waits for `fill_valid_i`. If `shared_i` was low during the read grant, the line becomes exclusive, and `cpu_done_o` pulses in the fill cycle with the selected fill word on `cpu_rdata_o`.
- R4: A load miss with `shared_i` high during the read grant fills the line as shared-clean.
- R5: A store miss issues BusRd. If `shared_i` was low, the store completes in the fill cycle and the line becomes modified with no further bus traffic. If `shared_i` was high, the fill cycle does not complete the store; a BusUpd follows, and the line ends as in R7.
- R6: A store that hits an exclusive or modified line completes in the same cycle without a bus request and leaves the line modified.
- R7: A store that hits a shared-clean or shared-owned line issues BusUpd (code 2). `bus_word_o` carries the word select and both halves of `bus_data_o` carry the new word. The store completes in the grant cycle. The line becomes shared-owned if `shared_i` is high during that grant, and modified otherwise.
- R8: A snooped BusUpd that hits a held line asserts `shared_o`, writes `snp_data_i` into the word chosen by `snp_word_i` and leaves the line shared-clean. A snooped update that misses, and any snooped Flush (code 3), changes nothing.
- R9: A snooped BusRd that hits asserts `shared_o`. A modified or shared-owned copy also raises `snp_flush_o`, with the line on `snp_flush_data_o` (word 1 in the upper half). Modified becomes shared-owned and exclusive becomes shared-clean.
- R10: A miss whose set holds a different line in shared-owned or modified state first issues Flush with that victim's line address and data, then BusRd. A clean victim is replaced with no write-back. The set index is the low log2(SETS) bits of the line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_line_i | input | LINE_AW | Line address of the request |
| cpu_word_i | input | 1 | Word select within the line |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Load data, valid with done |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant, one cycle per transaction |
| bus_cmd_o | output | 2 | Command: 0 none, 1 BusRd, 2 BusUpd, 3 Flush |
| bus_line_o | output | LINE_AW | Line address of the issued command |
| bus_word_o | output | 1 | Word select for BusUpd |
| bus_data_o | output | 2*DATA_W | Update word (both halves) or write-back line |
| shared_i | input | 1 | Wired-OR shared signal from the other caches |
| fill_valid_i | input | 1 | Fill data for the outstanding BusRd is valid |
| fill_data_i | input | 2*DATA_W | Fill line, word 1 in the upper half |
| snp_valid_i | input | 1 | Another master's bus command is visible |
| snp_cmd_i | input | 2 | Snooped command code |
| snp_line_i | input | LINE_AW | Snooped line address |
| snp_word_i | input | 1 | Snooped update word select |
| snp_data_i | input | DATA_W | Snooped update word |
| shared_o | output | 1 | This cache's shared contribution |
| snp_flush_o | output | 1 | This cache supplies the snooped line |
| snp_flush_data_o | output | 2*DATA_W | Line supplied on a snooped read |

## Verification
The hardest case to reach is a dirty write-back on a miss. It needs a set to hold an owned line under one tag, with a request for the other tag arriving later. Reaching the shared-owned variant also takes a snooped read or a shared update in between. The stimulus limits addresses to two tags across four sets. It mixes processor operations with snooped reads, updates and flushes, and randomizes the shared answers and grant delays. This drives every set through repeated ownership changes and evictions. Directed steps first walk one set through exclusive, modified, shared-owned and shared-clean, and then force both a dirty and a clean eviction.

// File: rtl/dcoh_pkg.sv
`timescale 1ns/1ps
package dcoh_pkg;
  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_EXC = 3'd1,
    ST_SC  = 3'd2,
    ST_SM  = 3'd3,
    ST_MOD = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RD    = 2'd1,
    CMD_UPD   = 2'd2,
    CMD_FLUSH = 2'd3
  } bus_cmd_e;

  function automatic logic is_owner(line_st_e s);
    return (s == ST_SM) || (s == ST_MOD);
  endfunction
endpackage

// File: rtl/dcoh_array.sv
`timescale 1ns/1ps
module dcoh_array
  import dcoh_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6,
  parameter int SETS   = 4,
  parameter int IDX_W  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  // port a: processor side
  input  logic [IDX_W-1:0]    a_idx_i,
  output line_st_e            a_st_o,
  output logic [TAG_W-1:0]    a_tag_o,
  output logic [2*DATA_W-1:0] a_line_o,
  input  logic                l_st_we_i,
  input  line_st_e            l_st_i,
  input  logic                l_fill_i,
  input  logic [TAG_W-1:0]    l_tag_i,
  input  logic [2*DATA_W-1:0] l_line_i,
  input  logic                l_word_we_i,
  input  logic                l_word_i,
  input  logic [DATA_W-1:0]   l_wdata_i,
  // port b: snoop side
  input  logic [IDX_W-1:0]    b_idx_i,
  output line_st_e            b_st_o,
  output logic [TAG_W-1:0]    b_tag_o,
  output logic [2*DATA_W-1:0] b_line_o,
  input  logic                s_st_we_i,
  input  line_st_e            s_st_i,
  input  logic                s_word_we_i,
  input  logic                s_word_i,
  input  logic [DATA_W-1:0]   s_wdata_i
);
  line_st_e                 st_q  [SETS];
  logic [TAG_W-1:0]         tag_q [SETS];
  logic [1:0][DATA_W-1:0]   dat_q [SETS];

  assign a_st_o   = st_q[a_idx_i];
  assign a_tag_o  = tag_q[a_idx_i];
  assign a_line_o = dat_q[a_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_line_o = dat_q[b_idx_i];

  // local writes come last so they win over a same-cycle snoop write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= ST_INV;
    end else begin
      for (int i = 0; i < SETS; i++) begin
        if (s_st_we_i && b_idx_i == IDX_W'(i)) st_q[i] <= s_st_i;
        if (l_st_we_i && a_idx_i == IDX_W'(i)) st_q[i] <= l_st_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < SETS; i++) begin
      if (s_word_we_i && b_idx_i == IDX_W'(i)) dat_q[i][s_word_i] <= s_wdata_i;
      if (l_fill_i && a_idx_i == IDX_W'(i)) begin
        dat_q[i] <= l_line_i;
        tag_q[i] <= l_tag_i;
      end
      if (l_word_we_i && a_idx_i == IDX_W'(i)) dat_q[i][l_word_i] <= l_wdata_i;
    end
  end

  p_fill_sets_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_fill_i |-> l_st_we_i && l_st_i != ST_INV);
endmodule

// File: rtl/dcoh_snoop.sv
`timescale 1ns/1ps
module dcoh_snoop
  import dcoh_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6
) (
  input  logic                snp_valid_i,
  input  bus_cmd_e            snp_cmd_i,
  input  logic [TAG_W-1:0]    snp_tag_i,
  input  line_st_e            st_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic [2*DATA_W-1:0] line_i,
  output logic                shared_o,
  output logic                flush_o,
  output logic [2*DATA_W-1:0] flush_data_o,
  output logic                st_we_o,
  output line_st_e            st_o,
  output logic                word_we_o
);
  logic hit;
  assign hit          = snp_valid_i && st_i != ST_INV && tag_i == snp_tag_i;
  assign flush_data_o = line_i;

  always_comb begin
    shared_o  = 1'b0;
    flush_o   = 1'b0;
    st_we_o   = 1'b0;
    st_o      = st_i;
    word_we_o = 1'b0;
    unique case (snp_cmd_i)
      CMD_RD: begin
        shared_o = hit;
        flush_o  = hit && is_owner(st_i);
        st_we_o  = hit && (st_i == ST_EXC || st_i == ST_MOD);
        st_o     = (st_i == ST_EXC) ? ST_SC : ST_SM;
      end
      CMD_UPD: begin
        shared_o  = hit;
        word_we_o = hit;
        st_we_o   = hit;
        st_o      = ST_SC;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dcoh_fsm.sv
`timescale 1ns/1ps
module dcoh_fsm
  import dcoh_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LINE_AW = 8,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [LINE_AW-1:0]  cpu_line_i,
  input  logic                cpu_word_i,
  input  logic [DATA_W-1:0]   cpu_wdata_i,
  output logic                cpu_done_o,
  output logic [DATA_W-1:0]   cpu_rdata_o,
  output logic                bus_req_o,
  input  logic                bus_gnt_i,
  output bus_cmd_e            bus_cmd_o,
  output logic [LINE_AW-1:0]  bus_line_o,
  output logic                bus_word_o,
  output logic [2*DATA_W-1:0] bus_data_o,
  input  logic                shared_i,
  input  logic                fill_valid_i,
  input  logic [2*DATA_W-1:0] fill_data_i,
  input  logic                snp_busy_i,
  input  line_st_e            st_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic [2*DATA_W-1:0] line_i,
  output logic                l_st_we_o,
  output line_st_e            l_st_o,
  output logic                l_fill_o,
  output logic                l_word_we_o
);
  typedef enum logic [2:0] {F_IDLE, F_WB, F_RD, F_FILL, F_UPD} fsm_e;

  fsm_e state_q, nxt;
  logic shared_q;
  logic hit;

  assign hit = st_i != ST_INV && tag_i == cpu_line_i[LINE_AW-1:IDX_W];

  always_comb begin
    nxt         = state_q;
    cpu_done_o  = 1'b0;
    cpu_rdata_o = cpu_word_i ? line_i[2*DATA_W-1:DATA_W] : line_i[DATA_W-1:0];
    bus_req_o   = 1'b0;
    bus_cmd_o   = CMD_NONE;
    bus_line_o  = cpu_line_i;
    bus_word_o  = cpu_word_i;
    bus_data_o  = {2{cpu_wdata_i}};
    l_st_we_o   = 1'b0;
    l_st_o      = st_i;
    l_fill_o    = 1'b0;
    l_word_we_o = 1'b0;
    unique case (state_q)
      F_IDLE: begin
        if (cpu_req_i && !snp_busy_i) begin
          if (hit) begin
            if (!cpu_we_i) begin
              cpu_done_o = 1'b1;
            end else if (st_i == ST_EXC || st_i == ST_MOD) begin
              l_word_we_o = 1'b1;
              l_st_we_o   = 1'b1;
              l_st_o      = ST_MOD;
              cpu_done_o  = 1'b1;
            end else begin
              nxt = F_UPD;
            end
          end else begin
            nxt = is_owner(st_i) ? F_WB : F_RD;
          end
        end
      end
      F_WB: begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = CMD_FLUSH;
        bus_line_o = {tag_i, cpu_line_i[IDX_W-1:0]};
        bus_data_o = line_i;
        if (bus_gnt_i) begin
          l_st_we_o = 1'b1;
          l_st_o    = ST_INV;
          nxt       = F_RD;
        end
      end
      F_RD: begin
        bus_req_o = 1'b1;
        bus_cmd_o = CMD_RD;
        if (bus_gnt_i) nxt = F_FILL;
      end
      F_FILL: begin
        cpu_rdata_o = cpu_word_i ? fill_data_i[2*DATA_W-1:DATA_W] : fill_data_i[DATA_W-1:0];
        if (fill_valid_i) begin
          l_fill_o  = 1'b1;
          l_st_we_o = 1'b1;
          if (!cpu_we_i) begin
            l_st_o     = shared_q ? ST_SC : ST_EXC;
            cpu_done_o = 1'b1;
            nxt        = F_IDLE;
          end else if (!shared_q) begin
            l_st_o      = ST_MOD;
            l_word_we_o = 1'b1;
            cpu_done_o  = 1'b1;
            nxt         = F_IDLE;
          end else begin
            l_st_o = ST_SC;
            nxt    = F_UPD;
          end
        end
      end
      F_UPD: begin
        bus_req_o = 1'b1;
        bus_cmd_o = CMD_UPD;
        if (bus_gnt_i) begin
          l_word_we_o = 1'b1;
          l_st_we_o   = 1'b1;
          l_st_o      = shared_i ? ST_SM : ST_MOD;
          cpu_done_o  = 1'b1;
          nxt         = F_IDLE;
        end
      end
      default: nxt = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= F_IDLE;
      shared_q <= 1'b0;
    end else begin
      state_q <= nxt;
      if (state_q == F_RD && bus_gnt_i) shared_q <= shared_i;
    end
  end

  p_wb_then_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == CMD_FLUSH) |=> (bus_req_o && bus_cmd_o == CMD_RD));
  p_rd_waits_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == CMD_RD) |=> !bus_req_o);
  p_upd_completes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == CMD_UPD) |-> cpu_done_o);
  p_done_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> cpu_req_i);
endmodule

// File: rtl/dcoh_ctrl.sv
`timescale 1ns/1ps
module dcoh_ctrl
  import dcoh_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LINE_AW = 8,
  parameter int SETS    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [LINE_AW-1:0]  cpu_line_i,
  input  logic                cpu_word_i,
  input  logic [DATA_W-1:0]   cpu_wdata_i,
  output logic                cpu_done_o,
  output logic [DATA_W-1:0]   cpu_rdata_o,
  output logic                bus_req_o,
  input  logic                bus_gnt_i,
  output logic [1:0]          bus_cmd_o,
  output logic [LINE_AW-1:0]  bus_line_o,
  output logic                bus_word_o,
  output logic [2*DATA_W-1:0] bus_data_o,
  input  logic                shared_i,
  input  logic                fill_valid_i,
  input  logic [2*DATA_W-1:0] fill_data_i,
  input  logic                snp_valid_i,
  input  logic [1:0]          snp_cmd_i,
  input  logic [LINE_AW-1:0]  snp_line_i,
  input  logic                snp_word_i,
  input  logic [DATA_W-1:0]   snp_data_i,
  output logic                shared_o,
  output logic                snp_flush_o,
  output logic [2*DATA_W-1:0] snp_flush_data_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_AW - IDX_W;

  line_st_e               a_st, b_st, l_st, s_st;
  logic [TAG_W-1:0]       a_tag, b_tag;
  logic [2*DATA_W-1:0]    a_line, b_line, l_line_unused;
  logic                   l_st_we, l_fill, l_word_we, s_st_we, s_word_we;
  bus_cmd_e               cmd;

  assign bus_cmd_o     = cmd;
  assign l_line_unused = fill_data_i;

  dcoh_array #(.DATA_W(DATA_W), .TAG_W(TAG_W), .SETS(SETS), .IDX_W(IDX_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_idx_i     (cpu_line_i[IDX_W-1:0]),
    .a_st_o      (a_st),
    .a_tag_o     (a_tag),
    .a_line_o    (a_line),
    .l_st_we_i   (l_st_we),
    .l_st_i      (l_st),
    .l_fill_i    (l_fill),
    .l_tag_i     (cpu_line_i[LINE_AW-1:IDX_W]),
    .l_line_i    (l_line_unused),
    .l_word_we_i (l_word_we),
    .l_word_i    (cpu_word_i),
    .l_wdata_i   (cpu_wdata_i),
    .b_idx_i     (snp_line_i[IDX_W-1:0]),
    .b_st_o      (b_st),
    .b_tag_o     (b_tag),
    .b_line_o    (b_line),
    .s_st_we_i   (s_st_we),
    .s_st_i      (s_st),
    .s_word_we_i (s_word_we),
    .s_word_i    (snp_word_i),
    .s_wdata_i   (snp_data_i)
  );

  dcoh_snoop #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_snoop (
    .snp_valid_i  (snp_valid_i),
    .snp_cmd_i    (bus_cmd_e'(snp_cmd_i)),
    .snp_tag_i    (snp_line_i[LINE_AW-1:IDX_W]),
    .st_i         (b_st),
    .tag_i        (b_tag),
    .line_i       (b_line),
    .shared_o     (shared_o),
    .flush_o      (snp_flush_o),
    .flush_data_o (snp_flush_data_o),
    .st_we_o      (s_st_we),
    .st_o         (s_st),
    .word_we_o    (s_word_we)
  );

  dcoh_fsm #(.DATA_W(DATA_W), .LINE_AW(LINE_AW), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_line_i   (cpu_line_i),
    .cpu_word_i   (cpu_word_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_done_o   (cpu_done_o),
    .cpu_rdata_o  (cpu_rdata_o),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_cmd_o    (cmd),
    .bus_line_o   (bus_line_o),
    .bus_word_o   (bus_word_o),
    .bus_data_o   (bus_data_o),
    .shared_i     (shared_i),
    .fill_valid_i (fill_valid_i),
    .fill_data_i  (fill_data_i),
    .snp_busy_i   (snp_valid_i),
    .st_i         (a_st),
    .tag_i        (a_tag),
    .line_i       (a_line),
    .l_st_we_o    (l_st_we),
    .l_st_o       (l_st),
    .l_fill_o     (l_fill),
    .l_word_we_o  (l_word_we)
  );

  p_flush_is_shared_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> shared_o);
  p_upd_never_flushes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 2'd2) |-> !snp_flush_o);
  p_snoop_flush_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 2'd3) |-> !shared_o && !snp_flush_o);
  p_idle_no_snoop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !shared_o && !snp_flush_o);
endmodule

// File: tb/test_dcoh_ctrl.sv
`timescale 1ns/1ps
module test_dcoh_ctrl;
  localparam int DW = 16, LAW = 8, NS = 4;
  localparam int S_INV = 0, S_EXC = 1, S_SC = 2, S_SM = 3, S_MOD = 4;

  logic            clk_i = 1'b0, rst_ni = 1'b0;
  logic            cpu_req_i = 0, cpu_we_i = 0, cpu_word_i = 0;
  logic [LAW-1:0]  cpu_line_i = '0;
  logic [DW-1:0]   cpu_wdata_i = '0;
  logic            cpu_done_o;
  logic [DW-1:0]   cpu_rdata_o;
  logic            bus_req_o, bus_gnt_i = 0, bus_word_o, shared_i = 0;
  logic [1:0]      bus_cmd_o;
  logic [LAW-1:0]  bus_line_o;
  logic [2*DW-1:0] bus_data_o;
  logic            fill_valid_i = 0;
  logic [2*DW-1:0] fill_data_i = '0;
  logic            snp_valid_i = 0, snp_word_i = 0;
  logic [1:0]      snp_cmd_i = '0;
  logic [LAW-1:0]  snp_line_i = '0;
  logic [DW-1:0]   snp_data_i = '0;
  logic            shared_o, snp_flush_o;
  logic [2*DW-1:0] snp_flush_data_o;

  dcoh_ctrl #(.DATA_W(DW), .LINE_AW(LAW), .SETS(NS)) i_dcoh_ctrl (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int m_st [NS];
  logic [LAW-3:0] m_tag [NS];
  logic [2*DW-1:0] m_d [NS];

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic owned(int s);
    return s == S_SM || s == S_MOD;
  endfunction

  task automatic expect_bus(input string rq, input logic [1:0] cmd, input logic [LAW-1:0] line,
                            input logic chkd, input logic [2*DW-1:0] data, input logic chkw,
                            input logic word, input logic sh, output logic done_seen);
    int n = 0;
    #1;
    while (!bus_req_o && n < 12) begin @(posedge clk_i); #2; n++; end
    chk({rq, " request"}, bus_req_o, 1);
    chk({rq, " command"}, bus_cmd_o, cmd);
    chk({rq, " line"}, bus_line_o, line);
    if (chkd) chk({rq, " data"}, bus_data_o, data);
    if (chkw) chk({rq, " word"}, bus_word_o, word);
    repeat ($urandom_range(0, 2)) begin
      @(posedge clk_i); #2;
      chk({rq, " request held"}, bus_req_o, 1);
    end
    bus_gnt_i = 1; shared_i = sh;
    #1 done_seen = cpu_done_o;
    @(posedge clk_i); #1;
    bus_gnt_i = 0; shared_i = 0;
  endtask

  task automatic cpu_op(input logic we, input logic [LAW-1:0] line, input logic word,
                        input logic [DW-1:0] wd, input logic sh_rd, input logic sh_upd);
    int idx = int'(line[1:0]);
    logic [LAW-3:0] tg = line[LAW-1:2];
    logic hit = m_st[idx] != S_INV && m_tag[idx] == tg;
    logic dn;
    logic [2*DW-1:0] fd;
    @(posedge clk_i); #1;
    cpu_req_i = 1; cpu_we_i = we; cpu_line_i = line; cpu_word_i = word; cpu_wdata_i = wd;
    if (hit && (!we || m_st[idx] == S_EXC || m_st[idx] == S_MOD)) begin
      #1;
      if (!we) begin
        chk("R2 load hit done", cpu_done_o, 1);
        chk("R2 load hit data", cpu_rdata_o, m_d[idx][word*DW +: DW]);
        chk("R2 load hit no bus", bus_req_o, 0);
      end else begin
        chk("R6 store hit done", cpu_done_o, 1);
        chk("R6 store hit no bus", bus_req_o, 0);
        m_d[idx][word*DW +: DW] = wd;
        m_st[idx] = S_MOD;
      end
      @(posedge clk_i); #1;
    end else if (hit) begin
      expect_bus("R7 update", 2'd2, line, 1, {wd, wd}, 1, word, sh_upd, dn);
      chk("R7 update done", dn, 1);
      m_d[idx][word*DW +: DW] = wd;
      m_st[idx] = sh_upd ? S_SM : S_MOD;
    end else begin
      if (owned(m_st[idx])) begin
        expect_bus("R10 write-back", 2'd3, {m_tag[idx], 2'(idx)}, 1, m_d[idx], 0, 0, 0, dn);
        chk("R10 write-back not done", dn, 0);
        m_st[idx] = S_INV;
      end
      expect_bus(sh_rd ? "R4 read" : "R3 read", 2'd1, line, 0, '0, 0, 0, sh_rd, dn);
      chk("R3 read not done", dn, 0);
      fd = {16'($urandom), 16'($urandom)};
      repeat ($urandom_range(0, 2)) begin @(posedge clk_i); #1; end
      fill_valid_i = 1; fill_data_i = fd;
      #1;
      m_tag[idx] = tg; m_d[idx] = fd;
      if (!we) begin
        chk(sh_rd ? "R4 fill done" : "R3 fill done", cpu_done_o, 1);
        chk(sh_rd ? "R4 fill data" : "R3 fill data", cpu_rdata_o, fd[word*DW +: DW]);
        m_st[idx] = sh_rd ? S_SC : S_EXC;
      end else if (!sh_rd) begin
        chk("R5 private store done", cpu_done_o, 1);
        m_d[idx][word*DW +: DW] = wd;
        m_st[idx] = S_MOD;
      end else begin
        chk("R5 shared store waits", cpu_done_o, 0);
        m_st[idx] = S_SC;
      end
      @(posedge clk_i); #1;
      fill_valid_i = 0;
      if (we && sh_rd) begin
        expect_bus("R5 update", 2'd2, line, 1, {wd, wd}, 1, word, sh_upd, dn);
        chk("R5 update done", dn, 1);
        m_d[idx][word*DW +: DW] = wd;
        m_st[idx] = sh_upd ? S_SM : S_MOD;
      end
    end
    cpu_req_i = 0;
  endtask

  task automatic snoop_op(input string rq, input logic [1:0] cmd, input logic [LAW-1:0] line,
                          input logic word, input logic [DW-1:0] data);
    int idx = int'(line[1:0]);
    logic hit = m_st[idx] != S_INV && m_tag[idx] == line[LAW-1:2];
    logic e_fl = hit && cmd == 2'd1 && owned(m_st[idx]);
    @(posedge clk_i); #1;
    snp_valid_i = 1; snp_cmd_i = cmd; snp_line_i = line; snp_word_i = word; snp_data_i = data;
    #1;
    chk({rq, " shared"}, shared_o, hit && (cmd == 2'd1 || cmd == 2'd2));
    chk({rq, " flush"}, snp_flush_o, e_fl);
    if (e_fl) chk({rq, " flush data"}, snp_flush_data_o, m_d[idx]);
    @(posedge clk_i); #1;
    snp_valid_i = 0;
    if (hit && cmd == 2'd1) begin
      if (m_st[idx] == S_EXC) m_st[idx] = S_SC;
      if (m_st[idx] == S_MOD) m_st[idx] = S_SM;
    end else if (hit && cmd == 2'd2) begin
      m_d[idx][word*DW +: DW] = data;
      m_st[idx] = S_SC;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) begin m_st[i] = S_INV; m_tag[i] = '0; m_d[i] = '0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    #1;
    chk("R1 reset bus idle", bus_req_o, 0);
    chk("R1 reset no done", cpu_done_o, 0);
    for (int i = 0; i < NS; i++) snoop_op("R1 reset snoop", 2'd1, 8'(i), 0, '0);

    cpu_op(0, 8'h00, 0, '0, 0, 0);            // R3 exclusive fill
    cpu_op(0, 8'h00, 1, '0, 0, 0);            // R2 other word hits
    cpu_op(1, 8'h00, 1, 16'hbeef, 0, 0);      // R6 E -> M
    cpu_op(1, 8'h00, 0, 16'h1111, 0, 0);      // R6 M stays M
    snoop_op("R9 owner read", 2'd1, 8'h00, 0, '0);
    cpu_op(1, 8'h00, 0, 16'h2222, 0, 1);      // R7 Sm stays Sm
    snoop_op("R8 update hit", 2'd2, 8'h00, 1, 16'h3333);
    cpu_op(0, 8'h00, 1, '0, 0, 0);            // R8 patched word reads back
    snoop_op("R8 update miss", 2'd2, 8'h04, 1, 16'h4444);
    snoop_op("R8 flush ignored", 2'd3, 8'h00, 0, 16'h5555);
    cpu_op(0, 8'h00, 1, '0, 0, 0);
    cpu_op(1, 8'h04, 0, 16'h6666, 1, 0);      // R5/R10 clean victim, shared store miss
    cpu_op(0, 8'h01, 1, '0, 1, 0);            // R4 shared fill
    cpu_op(0, 8'h00, 0, '0, 0, 0);            // R10 dirty victim
    cpu_op(1, 8'h05, 1, 16'h7777, 0, 0);      // R5 private store miss
    snoop_op("R9 exclusive read", 2'd1, 8'h00, 0, '0);

    for (int k = 0; k < 600; k++) begin
      logic [LAW-1:0] ln = 8'($urandom_range(0, 7));
      if ($urandom_range(0, 9) < 6)
        cpu_op(1'($urandom), ln, 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
      else
        snoop_op("R9 random snoop", 2'($urandom_range(1, 3)), ln, 1'($urandom), 16'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule